// File: doc/BRIEF.md
# Serial PHY Management Master

This block runs single management transactions toward an external PHY over a two-wire link: a clock line it generates (MDC) and a shared data line (MDIO). The data line is modelled as three pins: an output value, an output enable and an input. A host sets the command fields and pulses `start`. The command fields are read-versus-write, a 5-bit PHY address, a 5-bit register address and, for writes, a 16-bit data word. The block then produces the whole 64-bit serial frame on its own and reports completion with a one-cycle `done`.

The management clock comes from the system clock through a divider whose half-period the host selects on `clk_div`. Each new frame bit appears on the data line one system clock after an MDC rising edge. Read data is sampled on MDC rising edges. During a read the block releases the data line at the first turnaround bit, so the PHY can drive a 0 and then the register contents. When the PHY fails to pull that turnaround bit low, the block raises a no-response flag together with `done`.

Top module: `mdio_master`

## Requirements
- R1: After reset `busy`, `done`, `no_resp`, `mdc` and `mdio_oe` are 0, `mdio_o` is 1 and `rdata` is 0.
- R2: While a frame runs, MDC is a square wave whose half-period is H = max(`clk_div`,1)+1 system clocks. It starts low in the cycle of acceptance and makes exactly 64 rising edges. The frame ends on the falling edge that follows the 64th rising edge, and MDC then stays low.
- R3: Frame bit i (i = 0..63) is bit 63-i of the word {32 ones, 0, 1, opcode, PHY address, register address, turnaround, data}. The opcode is 10 for a read and 01 for a write. Both addresses go out MSB first.
- R4: In a write, the turnaround is 1 then 0 and the data goes out D15 first. `mdio_oe` stays 1 for all 64 bits.
- R5: In a read, `mdio_oe` is 1 for bits 0..45 and 0 from bit 46 (the first turnaround bit) to the end of the frame. `mdio_oe` is 0 whenever the block is idle.
- R6: Frame bit 0 appears one system clock after acceptance. Bit k+1 replaces bit k one system clock after the (k+1)th MDC rising edge, so the data line never changes in a cycle where MDC has just risen.
- R7: `start` is accepted only while `busy` is 0. A `start` pulse during a frame, even with changed command fields, does not alter the running frame and does not start another one.
- R8: `busy` rises the cycle after `start` is accepted and stays high until the frame-ending MDC fall. In that cycle `done` is 1 for exactly one system clock and `busy` is already 0.
- R9: On a read, the data line is sampled at the MDC rising edges of bits 48..63 (D15 first). The word appears on `rdata` in the `done` cycle and holds until the next read completes. Writes leave it unchanged.
- R10: `no_resp` is 1 only in the `done` cycle of a read whose bit 47 (second turnaround) was sampled as 1. It is never set by a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_div | input | 8 | MDC half-period select; half-period is max(value,1)+1 clocks |
| start | input | 1 | Request a transaction (taken only when idle) |
| op_read | input | 1 | 1 = read, 0 = write |
| phy_addr | input | 5 | Target PHY address |
| reg_addr | input | 5 | Target register address |
| wdata | input | 16 | Write data |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle completion pulse |
| no_resp | output | 1 | Read turnaround not driven low (valid with done) |
| rdata | output | 16 | Last completed read word |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input |

## Verification
Writes carry asymmetric words such as A55A and 0001 to edge-aligned addresses 00000, 11111 and 10000. A bit-order or field-position error therefore shifts a distinct pattern. Reads return 1234 and 8001, which tell MSB-first capture apart from LSB-first capture and expose off-by-one sampling. A read with the turnaround left high separates the no-response path from normal completion. The divider is run at 0, 1, 2 and 3, which checks the clamp and the half-period scaling. Reads and writes are interleaved, and a second `start` with altered fields is pulsed in mid-frame, to show that a running frame and the held read word stay untouched.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
   localparam logic [1:0] START_PAT = 2'b01;
   localparam logic [1:0] OPC_READ  = 2'b10;
   localparam logic [1:0] OPC_WRITE = 2'b01;
   localparam logic [1:0] TURN_WR   = 2'b10;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SHIFT = 2'd1,
      ST_TAIL  = 2'd2
   } mdio_state_e;

   function automatic int frame_bits(input int pre, input int aw, input int dw);
      return pre + 4 + 2 * aw + 2 + dw;
   endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             clear,
   input  logic [DIV_W-1:0] div,
   output logic             mdc,
   output logic             rise,
   output logic             fall
);
   logic [DIV_W-1:0] cnt;
   logic [DIV_W-1:0] limit;
   logic             wrap;

   assign limit = (div == '0) ? DIV_W'(1) : div;
   assign wrap  = run && (cnt == limit);
   assign rise  = wrap && !mdc;
   assign fall  = wrap && mdc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         mdc <= 1'b0;
      end else if (clear || !run) begin
         cnt <= '0;
         mdc <= 1'b0;
      end else if (wrap) begin
         cnt <= '0;
         mdc <= ~mdc;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter #(
   parameter int FRAME_LEN = 64,
   parameter int REL_IDX   = 46
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load,
   input  logic [FRAME_LEN-1:0] frame_in,
   input  logic                 adv,
   input  logic                 active,
   input  logic                 is_read,
   output logic [$clog2(FRAME_LEN)-1:0] idx,
   output logic                 last,
   output logic                 line_o,
   output logic                 line_oe
);
   localparam int IDX_W = $clog2(FRAME_LEN);

   logic [FRAME_LEN-1:0] sreg;

   assign last = (idx == IDX_W'(FRAME_LEN - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg <= '1;
         idx  <= '0;
      end else if (load) begin
         sreg <= frame_in;
         idx  <= '0;
      end else if (adv && !last) begin
         sreg <= {sreg[FRAME_LEN-2:0], 1'b1};
         idx  <= idx + 1'b1;
      end
   end

   // Output stage lags the shift register by one clock: launch margin after MDC rise.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_o  <= 1'b1;
         line_oe <= 1'b0;
      end else begin
         line_o  <= active ? sreg[FRAME_LEN-1] : 1'b1;
         line_oe <= active && (!is_read || (idx < IDX_W'(REL_IDX)));
      end
   end
endmodule

// File: rtl/mdio_capture.sv
module mdio_capture #(
   parameter int FRAME_LEN = 64,
   parameter int DATA_W    = 16,
   parameter int TA_IDX    = 47
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         sample,
   input  logic [$clog2(FRAME_LEN)-1:0] idx,
   input  logic                         line_i,
   input  logic                         commit,
   output logic [DATA_W-1:0]            word,
   output logic                         ta_high
);
   localparam int IDX_W = $clog2(FRAME_LEN);

   logic [DATA_W-1:0] shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg   <= '0;
         ta_high <= 1'b0;
      end else if (sample) begin
         if (idx == IDX_W'(TA_IDX)) ta_high <= line_i;
         if (idx >  IDX_W'(TA_IDX)) shreg   <= {shreg[DATA_W-2:0], line_i};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      word <= '0;
      else if (commit) word <= shreg;
   end
endmodule

// File: rtl/mdio_master.sv
module mdio_master #(
   parameter int PRE_LEN = 32,
   parameter int ADDR_W  = 5,
   parameter int DATA_W  = 16,
   parameter int DIV_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DIV_W-1:0]  clk_div,
   input  logic              start,
   input  logic              op_read,
   input  logic [ADDR_W-1:0] phy_addr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] wdata,
   output logic              busy,
   output logic              done,
   output logic              no_resp,
   output logic [DATA_W-1:0] rdata,
   output logic              mdc,
   output logic              mdio_o,
   output logic              mdio_oe,
   input  logic              mdio_i
);
   import mdio_pkg::*;

   localparam int FRAME_LEN = frame_bits(PRE_LEN, ADDR_W, DATA_W);
   localparam int IDX_W     = $clog2(FRAME_LEN);
   localparam int REL_IDX   = PRE_LEN + 4 + 2 * ADDR_W;
   localparam int TA_IDX    = REL_IDX + 1;

   if (PRE_LEN < 1) begin : g_bad_pre
      $error("PRE_LEN must be at least 1");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("ADDR_W must be at least 1");
   end
   if (DATA_W < 2) begin : g_bad_data
      $error("DATA_W must be at least 2");
   end
   if (DIV_W < 2) begin : g_bad_div
      $error("DIV_W must be at least 2");
   end

   mdio_state_e          state;
   logic                 rd_q;
   logic                 accept;
   logic                 rise, fall;
   logic                 last;
   logic [IDX_W-1:0]     idx;
   logic                 ta_high;
   logic                 finish;
   logic [FRAME_LEN-1:0] frame;

   assign busy   = (state != ST_IDLE);
   assign accept = (state == ST_IDLE) && start;
   assign finish = (state == ST_TAIL) && fall;

   assign frame = {{PRE_LEN{1'b1}}, START_PAT,
                   op_read ? OPC_READ : OPC_WRITE,
                   phy_addr, reg_addr,
                   op_read ? 2'b11 : TURN_WR,
                   op_read ? {DATA_W{1'b1}} : wdata};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         rd_q    <= 1'b0;
         done    <= 1'b0;
         no_resp <= 1'b0;
      end else begin
         done    <= finish;
         no_resp <= finish && rd_q && ta_high;
         unique case (state)
            ST_IDLE: if (start) begin
               state <= ST_SHIFT;
               rd_q  <= op_read;
            end
            ST_SHIFT: if (rise && last) state <= ST_TAIL;
            ST_TAIL:  if (fall)         state <= ST_IDLE;
            default:                    state <= ST_IDLE;
         endcase
      end
   end

   mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (busy),
      .clear (accept),
      .div   (clk_div),
      .mdc   (mdc),
      .rise  (rise),
      .fall  (fall)
   );

   mdio_shifter #(.FRAME_LEN(FRAME_LEN), .REL_IDX(REL_IDX)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .frame_in (frame),
      .adv      (rise && (state == ST_SHIFT)),
      .active   (busy),
      .is_read  (rd_q),
      .idx      (idx),
      .last     (last),
      .line_o   (mdio_o),
      .line_oe  (mdio_oe)
   );

   mdio_capture #(.FRAME_LEN(FRAME_LEN), .DATA_W(DATA_W), .TA_IDX(TA_IDX)) u_cap (
      .clk     (clk),
      .rst_n   (rst_n),
      .sample  (rise && rd_q && (state == ST_SHIFT)),
      .idx     (idx),
      .line_i  (mdio_i),
      .commit  (finish && rd_q),
      .word    (rdata),
      .ta_high (ta_high)
   );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              done,
   input logic              no_resp,
   input logic [DATA_W-1:0] rdata,
   input logic              mdc,
   input logic              mdio_o,
   input logic              mdio_oe
);
   p_reset_state_r1: assert property (@(posedge clk) !rst_n |-> !busy && !mdc && !mdio_oe);

   p_mdc_low_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mdc);

   p_oe_off_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !done) |-> !mdio_oe);

   p_launch_after_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !$stable(mdio_o)) |-> (mdc && $past(mdc)));

   p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_ends_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));

   p_rdata_only_at_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rdata) |-> done);

   p_noresp_with_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
      no_resp |-> done);
endmodule

bind mdio_master mdio_master_chk #(.DATA_W(DATA_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .busy    (busy),
   .done    (done),
   .no_resp (no_resp),
   .rdata   (rdata),
   .mdc     (mdc),
   .mdio_o  (mdio_o),
   .mdio_oe (mdio_oe)
);

// File: tb/mdio_master_test.sv
`timescale 1ns/1ps
module mdio_master_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  clk_div = 8'd1;
   logic        start = 1'b0;
   logic        op_read = 1'b0;
   logic [4:0]  phy_addr = '0;
   logic [4:0]  reg_addr = '0;
   logic [15:0] wdata = '0;
   logic        busy, done, no_resp, mdc, mdio_o, mdio_oe;
   logic [15:0] rdata;
   logic        mdio_i = 1'b1;

   integer checks = 0;
   integer errors = 0;
   logic [15:0] held_rdata = 16'h0000;

   always #2.5 clk = ~clk;

   mdio_master uut (
      .clk(clk), .rst_n(rst_n), .clk_div(clk_div), .start(start),
      .op_read(op_read), .phy_addr(phy_addr), .reg_addr(reg_addr),
      .wdata(wdata), .busy(busy), .done(done), .no_resp(no_resp),
      .rdata(rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
      .mdio_i(mdio_i)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
      end
   endtask

   function automatic int bit_idx(input int t, input int h);
      int i;
      i = (t + h) / (2 * h);
      return (i > 63) ? 63 : i;
   endfunction

   // One transaction, compared against the behavioural model on every clock.
   task automatic run(input bit rd, input logic [4:0] pa, input logic [4:0] ra,
                      input logic [15:0] wd, input logic [7:0] dv,
                      input logic [15:0] phy_word, input bit ta_val, input bit poke);
      int h, t_end, i, ip;
      logic [63:0] f;
      bit e_busy, e_mdc, e_oe, e_mdo, e_done, e_nr;
      h = ((dv == 0) ? 1 : int'(dv)) + 1;
      t_end = 128 * h;
      f = {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), pa, ra, 2'b10, wd};
      @(negedge clk);
      op_read = rd; phy_addr = pa; reg_addr = ra; wdata = wd; clk_div = dv;
      start = 1'b1;
      for (int t = 0; t <= t_end + 1; t++) begin
         @(posedge clk);
         @(negedge clk);
         if (t == 0) start = 1'b0;
         if (poke && t == 5) begin
            start = 1'b1; op_read = ~rd; phy_addr = ~pa; reg_addr = ~ra; wdata = ~wd;
         end
         if (poke && t == 6) start = 1'b0;
         if (poke && t == t_end + 1) start = 1'b0;
         e_busy = (t < t_end);
         e_mdc  = (t < t_end) ? (((t / h) % 2) == 1) : 1'b0;
         e_done = (t == t_end);
         e_nr   = e_done && rd && ta_val;
         if (t == 0 || t > t_end) begin
            e_oe = 1'b0; e_mdo = 1'b1;
         end else begin
            ip = bit_idx(t - 1, h);
            e_oe = !rd || (ip < 46);
            e_mdo = f[63 - ip];
         end
         if (t == t_end && rd) held_rdata = phy_word;
         check(busy === e_busy, "R8", "busy", busy, e_busy);
         check(done === e_done, "R8", "done", done, e_done);
         check(mdc === e_mdc, "R2", "mdc", mdc, e_mdc);
         check(mdio_oe === e_oe, rd ? "R5" : "R4", "mdio_oe", mdio_oe, e_oe);
         if (e_oe) check(mdio_o === e_mdo, "R3/R6", "mdio_o", mdio_o, e_mdo);
         check(no_resp === e_nr, "R10", "no_resp", no_resp, e_nr);
         if (t >= t_end)
            check(rdata === held_rdata, "R9", "rdata", rdata, held_rdata);
         if (poke && t == t_end + 1)
            check(busy === 1'b0, "R7", "no restart", busy, 0);
         // PHY model: value for the bit currently on the line
         i = bit_idx(t, h);
         if (rd && t < t_end && i == 47)      mdio_i = ta_val;
         else if (rd && t < t_end && i >= 48) mdio_i = phy_word[63 - i];
         else                                 mdio_i = 1'b1;
      end
      op_read = 1'b0; mdio_i = 1'b1;
   endtask

   initial begin
      #1_000_000;
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(busy === 1'b0 && done === 1'b0 && no_resp === 1'b0, "R1", "flags", {busy, done, no_resp}, 0);
      check(mdc === 1'b0 && mdio_oe === 1'b0, "R1", "mdc/oe", {mdc, mdio_oe}, 0);
      check(mdio_o === 1'b1, "R1", "mdio_o", mdio_o, 1);
      check(rdata === 16'h0000, "R1", "rdata", rdata, 0);
      rst_n = 1'b1;
      // R4 write, minimum divider
      run(1'b0, 5'h01, 5'h00, 16'hA55A, 8'd1, 16'h0000, 1'b0, 1'b0);
      // R9 read with a mid-frame start (R7), divider 3
      run(1'b1, 5'h1F, 5'h15, 16'h0000, 8'd3, 16'h1234, 1'b0, 1'b1);
      // R9 hold across write, divider 0 clamp (R2)
      run(1'b0, 5'h10, 5'h1F, 16'h0001, 8'd0, 16'h0000, 1'b0, 1'b0);
      // R10 no response on read
      run(1'b1, 5'h0A, 5'h05, 16'h0000, 8'd2, 16'hFFFF, 1'b1, 1'b0);
      // R9 MSB-first capture, R7 poke again
      run(1'b1, 5'h00, 5'h1F, 16'h0000, 8'd0, 16'h8001, 1'b0, 1'b1);
      repeat (4) @(negedge clk);
      check(busy === 1'b0 && mdc === 1'b0, "R2", "idle after frames", {busy, mdc}, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule